// File: doc/BRIEF.md
# Strobe-Latched Seven-Segment Digit Store

This block is the storage and decode stage of a multiplexed numeric display. A host presents a 4-bit digit code, two indicator flags and a digit index on parallel input pins, then raises a chip-select strobe. The block carries the strobe and the bus into the system clock domain. On the strobe's rising edge it commits the code and the flags to the one digit slot that the index selects. The other slots keep their contents.

Every slot keeps its code, its two flags and a written marker. A slot that has not been written since reset shows nothing. The stored code is translated into a seven-segment pattern through one of two tables, chosen by a live mode input. One table is hexadecimal. The other is a numeric table with a few letters. All slot patterns and flags are presented in parallel to a downstream scan multiplexer.

A shutdown input darkens every segment and flag output at once. The stored contents survive shutdown, and writes are still accepted while it is asserted.

Top module: `strobe_digit_store`

## Requirements
- R1: After reset every slot is unwritten: every segment output bit and every flag output bit reads 0 in both decode modes.
- R2: A rising edge on `cs_in` writes `data_in` and `ann_in` into the slot given by `addr_in`. Slot k drives `seg_out[7k+6:7k]` and `ann_out[2k+1:2k]`. The segment bit order is a (bit 0) through g (bit 6), and `ann_in[0]` lands in bit 2k.
- R3: A write leaves every slot other than the addressed one unchanged.
- R4: A strobe produces exactly one write. Changing the bus while `cs_in` stays high writes nothing, and the falling edge of `cs_in` writes nothing.
- R5: With `hex_mode`=1, codes 0 to 15 show 0-9, A, b, C, d, E, F as conventional seven-segment glyphs.
- R6: With `hex_mode`=0, codes 0 to 9 show digits, and codes 10 to 15 show dash (g only), E, H, L, P and blank in that order.
- R7: `hex_mode` acts on the stored codes without a rewrite, so all slots follow a mode change in the same cycle.
- R8: While `shdn` is 1, all `seg_out` and `ann_out` bits are 0. A write made during shutdown is stored and appears once `shdn` returns to 0.
- R9: When `cs_in` rises ahead of a clock edge E1, the written slot changes after edge E(SYNC_STAGES+1) and not earlier. With the default of two stages, the slot changes after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_in | input | 1 | Write strobe; its rising edge commits the bus |
| data_in | input | 4 | Digit code, bit 0 least significant |
| addr_in | input | $clog2(NUM_DIGITS) | Slot index, bit 0 least significant |
| ann_in | input | 2 | Indicator flags, 1 = on |
| hex_mode | input | 1 | 1 = hexadecimal table, 0 = numeric-with-letters table |
| shdn | input | 1 | 1 = darken all outputs |
| seg_out | output | 7*NUM_DIGITS | Segment patterns, 7 bits per slot |
| ann_out | output | 2*NUM_DIGITS | Indicator flags, 2 bits per slot |

## Verification
Two functions can fall in the same cycle: a committed write, and the shutdown blanking or a decode-mode switch that acts on the slots at that moment. The bench raises the strobe while `shdn` is held high. It requires the outputs to stay dark throughout, and then requires the written value to appear as soon as shutdown is released. A separate exhaustive sweep writes every code into every slot and switches the decode mode straight after each write. Each check compares all slots against a bench-side model of the contents.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // Segment bit order: bit0 = a ... bit6 = g.
  function automatic seg_t numeral_glyph(input code_t c);
    seg_t s;
    case (c)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

  function automatic seg_t hex_glyph(input code_t c);
    seg_t s;
    case (c)
      4'd10:   s = 7'h77;
      4'd11:   s = 7'h7C;
      4'd12:   s = 7'h39;
      4'd13:   s = 7'h5E;
      4'd14:   s = 7'h79;
      4'd15:   s = 7'h71;
      default: s = numeral_glyph(c);
    endcase
    return s;
  endfunction

  function automatic seg_t letter_glyph(input code_t c);
    seg_t s;
    case (c)
      4'd10:   s = 7'h40;
      4'd11:   s = 7'h79;
      4'd12:   s = 7'h76;
      4'd13:   s = 7'h38;
      4'd14:   s = 7'h73;
      4'd15:   s = 7'h00;
      default: s = numeral_glyph(c);
    endcase
    return s;
  endfunction

  function automatic seg_t slot_glyph(input code_t c, input logic hex,
                                      input logic written, input logic dark);
    seg_t s;
    if (dark || !written) s = '0;
    else if (hex)         s = hex_glyph(c);
    else                  s = letter_glyph(c);
    return s;
  endfunction

endpackage

// File: rtl/sdd_sync.sv
module sdd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[i] <= '0;
        else if (i == 0) chain[i] <= d;
        else             chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sdd_rise_detect.sv
module sdd_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign pulse = lvl && !lvl_q;
endmodule

// File: rtl/sdd_slot.sv
module sdd_slot
  import sdd_pkg::*;
#(
  parameter int ANN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  code_t            code_d,
  input  logic [ANN_W-1:0] ann_d,
  input  logic             hex_mode,
  input  logic             shdn,
  output code_t            code_q,
  output logic [ANN_W-1:0] ann_q,
  output logic             vld_q,
  output seg_t             seg,
  output logic [ANN_W-1:0] ann_vis
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ann_q  <= '0;
      vld_q  <= 1'b0;
    end else if (we) begin
      code_q <= code_d;
      ann_q  <= ann_d;
      vld_q  <= 1'b1;
    end
  end

  assign seg     = slot_glyph(code_q, hex_mode, vld_q, shdn);
  assign ann_vis = shdn ? '0 : ann_q;
endmodule

// File: rtl/strobe_digit_store.sv
module strobe_digit_store
  import sdd_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int ANN_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_in,
  input  logic [CODE_W-1:0]           data_in,
  input  logic [ADDR_W-1:0]           addr_in,
  input  logic [ANN_W-1:0]            ann_in,
  input  logic                        hex_mode,
  input  logic                        shdn,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_out,
  output logic [NUM_DIGITS*ANN_W-1:0] ann_out
);
  localparam int BUS_W = 1 + CODE_W + ADDR_W + ANN_W;

  logic [BUS_W-1:0] bus_raw, bus_sync;
  logic             cs_sync;
  logic             wr_fire;
  code_t            wr_code;
  logic [ADDR_W-1:0] wr_addr;
  logic [ANN_W-1:0] wr_ann;

  logic [NUM_DIGITS*CODE_W-1:0] store_code;
  logic [NUM_DIGITS*ANN_W-1:0]  store_ann;
  logic [NUM_DIGITS-1:0]        store_vld;

  assign bus_raw = {cs_in, data_in, addr_in, ann_in};

  sdd_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_sync)
  );

  assign {cs_sync, wr_code, wr_addr, wr_ann} = bus_sync;

  sdd_rise_detect u_rise (
    .clk(clk), .rst_n(rst_n), .lvl(cs_sync), .pulse(wr_fire)
  );

  generate
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_slot
      logic slot_we;
      assign slot_we = wr_fire && (wr_addr == ADDR_W'(k));

      sdd_slot #(.ANN_W(ANN_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (slot_we),
        .code_d   (wr_code),
        .ann_d    (wr_ann),
        .hex_mode (hex_mode),
        .shdn     (shdn),
        .code_q   (store_code[k*CODE_W +: CODE_W]),
        .ann_q    (store_ann[k*ANN_W +: ANN_W]),
        .vld_q    (store_vld[k]),
        .seg      (seg_out[k*SEG_W +: SEG_W]),
        .ann_vis  (ann_out[k*ANN_W +: ANN_W])
      );
    end
  endgenerate
endmodule

// File: rtl/strobe_digit_store_chk.sv
module strobe_digit_store_chk #(
  parameter int NUM_DIGITS = 8,
  parameter int ANN_W      = 2,
  parameter int ADDR_W     = 3,
  parameter int CODE_W     = 4,
  parameter int SEG_W      = 7
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         shdn,
  input logic                         wr_fire,
  input logic [ADDR_W-1:0]            wr_addr,
  input logic [CODE_W-1:0]            wr_code,
  input logic [ANN_W-1:0]             wr_ann,
  input logic [NUM_DIGITS*CODE_W-1:0] store_code,
  input logic [NUM_DIGITS*ANN_W-1:0]  store_ann,
  input logic [NUM_DIGITS-1:0]        store_vld,
  input logic [NUM_DIGITS*SEG_W-1:0]  seg_out,
  input logic [NUM_DIGITS*ANN_W-1:0]  ann_out
);
  logic              fire_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CODE_W-1:0] code_q;
  logic [ANN_W-1:0]  ann_q;
  logic [CODE_W-1:0] pick_code;
  logic [ANN_W-1:0]  pick_ann;
  logic              pick_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      addr_q <= '0;
      code_q <= '0;
      ann_q  <= '0;
    end else begin
      fire_q <= wr_fire;
      addr_q <= wr_addr;
      code_q <= wr_code;
      ann_q  <= wr_ann;
    end
  end

  always_comb begin
    pick_code = '0;
    pick_ann  = '0;
    pick_vld  = 1'b0;
    for (int k = 0; k < NUM_DIGITS; k++) begin
      if (addr_q == ADDR_W'(k)) begin
        pick_code = store_code[k*CODE_W +: CODE_W];
        pick_ann  = store_ann[k*ANN_W +: ANN_W];
        pick_vld  = store_vld[k];
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (pick_vld && pick_code == code_q && pick_ann == ann_q)); // R2

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> ($stable(store_code) && $stable(store_ann) && $stable(store_vld))); // R3

  AST_ONE_SLOT_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(store_vld) <= $countones($past(store_vld)) + 1); // R3

  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire); // R4

  AST_SHDN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |-> (seg_out == '0 && ann_out == '0)); // R8
endmodule

bind strobe_digit_store strobe_digit_store_chk #(
  .NUM_DIGITS(NUM_DIGITS), .ANN_W(ANN_W), .ADDR_W(ADDR_W),
  .CODE_W(sdd_pkg::CODE_W), .SEG_W(sdd_pkg::SEG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn(shdn), .wr_fire(wr_fire),
  .wr_addr(wr_addr), .wr_code(wr_code), .wr_ann(wr_ann),
  .store_code(store_code), .store_ann(store_ann), .store_vld(store_vld),
  .seg_out(seg_out), .ann_out(ann_out)
);

// File: tb/strobe_digit_store_tb.sv
module strobe_digit_store_tb;
  localparam int ND = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cs_in = 1'b0;
  logic [3:0] data_in = '0;
  logic [2:0] addr_in = '0;
  logic [1:0] ann_in = '0;
  logic hex_mode = 1'b1;
  logic shdn = 1'b0;
  logic [ND*7-1:0] seg_out;
  logic [ND*2-1:0] ann_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0] m_code [ND];
  logic [1:0] m_ann  [ND];
  logic       m_vld  [ND];

  always #10 clk = ~clk;

  strobe_digit_store u_dut (
    .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .data_in(data_in),
    .addr_in(addr_in), .ann_in(ann_in), .hex_mode(hex_mode), .shdn(shdn),
    .seg_out(seg_out), .ann_out(ann_out)
  );

  // Conventional glyphs, segment a in bit 0.
  function automatic logic [6:0] glyph(input logic [3:0] c, input logic hx);
    logic [6:0] t [16];
    t = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
          7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    if (hx || c < 4'd10) return t[c];
    case (c)
      4'd10:   return 7'h40;
      4'd11:   return 7'h79;
      4'd12:   return 7'h76;
      4'd13:   return 7'h38;
      4'd14:   return 7'h73;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check_all(input string tag);
    for (int d = 0; d < ND; d++) begin
      logic [6:0] es;
      logic [1:0] ea;
      es = (shdn || !m_vld[d]) ? 7'h00 : glyph(m_code[d], hex_mode);
      ea = (shdn || !m_vld[d]) ? 2'b00 : m_ann[d];
      if (shdn) ea = 2'b00;
      else      ea = m_ann[d];
      checks++;
      if (seg_out[d*7 +: 7] !== es || ann_out[d*2 +: 2] !== ea) begin
        failures++;
        $display("FAIL %s slot %0d: seg=%h ann=%b expected seg=%h ann=%b",
                 tag, d, seg_out[d*7 +: 7], ann_out[d*2 +: 2], es, ea);
      end
    end
  endtask

  task automatic put_bus(input int a, input int c, input int an);
    addr_in = 3'(a);
    data_in = 4'(c);
    ann_in  = 2'(an);
  endtask

  task automatic do_write(input int a, input int c, input int an);
    @(negedge clk);
    put_bus(a, c, an);
    @(negedge clk);
    cs_in = 1'b1;
    repeat (3) @(negedge clk);
    cs_in = 1'b0;
    m_code[a] = 4'(c);
    m_ann[a]  = 2'(an);
    m_vld[a]  = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int d = 0; d < ND; d++) begin
      m_code[d] = '0; m_ann[d] = '0; m_vld[d] = 1'b0;
    end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state in both tables
    hex_mode = 1'b1; #1 check_all("R1");
    hex_mode = 1'b0; #1 check_all("R1");

    // R2 R3 R5 R6 R7: every code into every slot, both tables after each write
    for (int a = 0; a < ND; a++) begin
      for (int c = 0; c < 16; c++) begin
        do_write(a, c, c % 4);
        hex_mode = 1'b1; #1 check_all("R2/R3/R5/R7");
        hex_mode = 1'b0; #1 check_all("R2/R3/R6/R7");
      end
    end

    // R9: latency of the write path
    hex_mode = 1'b1;
    @(negedge clk);
    put_bus(6, 8, 2);
    @(negedge clk);
    cs_in = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R9 early");
    @(negedge clk);
    m_code[6] = 4'd8; m_ann[6] = 2'd2;
    check_all("R9 landed");
    cs_in = 1'b0;
    repeat (3) @(negedge clk);

    // R4: bus changes while strobe high, and the falling edge, write nothing
    do_write(3, 5, 1);
    @(negedge clk);
    put_bus(3, 9, 3);
    @(negedge clk);
    cs_in = 1'b1;
    repeat (4) @(negedge clk);
    m_code[3] = 4'd9; m_ann[3] = 2'd3;
    put_bus(3, 2, 0);
    repeat (5) @(negedge clk);
    check_all("R4 held");
    put_bus(3, 7, 2);
    repeat (3) @(negedge clk);
    cs_in = 1'b0;
    repeat (5) @(negedge clk);
    check_all("R4 fall");

    // R8: shutdown darkens, a write during shutdown is kept
    shdn = 1'b1; #1 check_all("R8 dark");
    do_write(0, 12, 3);
    check_all("R8 dark write");
    hex_mode = 1'b0;
    shdn = 1'b0; #1 check_all("R8 revealed");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule